// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration space of each function that sits behind one bus number. A single access port carries a packed configuration address, a write data word, a size code, a write flag and a strobe. The block decodes the target function. It merges write bytes through a per-offset writable mask, so the identity fields and reserved header bytes keep their values. It returns read data one cycle after the strobe.

Base-address registers take their writable masks from the size parameters. The expansion-ROM register also has a writable enable bit. When a write alters the base-address window, or toggles either decode-enable bit of the command register, the block emits a one-cycle remap pulse so that downstream address decoding can be rebuilt. An access to a bus number other than the block's own, or to a function index that is not populated, reads as all ones. A write to such a target changes nothing.

Top module: `cfg_space_regfile`

## Requirements
- R1: `cfg_addr[23:16]` is compared against `BUS_NUM`. `cfg_addr[15:8]` selects function index 0 to `NUM_FUNCS`-1. `cfg_addr[7:0]` is the starting byte offset. Each function has its own storage.
- R2: A read whose bus does not match, or whose function index is `NUM_FUNCS` or more, returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for size codes 0, 1 and 2/3. A write to such a target changes no byte and raises no remap pulse.
- R3: Size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. Byte k of the data word maps to offset+k in both directions. Read bits above the moved bytes are zero.
- R4: A 4-byte read is served only at offset 0xFC or below. Otherwise it is served as 2 bytes if the offset is 0xFE or below, and as 1 byte if not. A 2-byte read at 0xFF is served as 1 byte.
- R5: Write bytes that would land past offset 0xFF are dropped. The bytes below 0xFF are still written.
- R6: Each written byte is stored as (old & ~mask) | (new & mask), using the writable mask of its offset.
- R7: Offsets 0x00-0x03 (vendor, then device, little-endian), 0x08 (revision), 0x09-0x0B (class code) and 0x0E (header type) hold their parameter values and never change.
- R8: Offsets 0x0C, 0x3C and 0x40-0xFF are fully writable. Only bits 2:0 of offset 0x04 are writable, and offset 0x05 is read-only. All other header bytes not covered by R7 or R9 are read-only zero.
- R9: A base register n at 0x10+4n with size exponent L (not 0) has writable mask ~(2^L-1). L=0 means absent: all bytes are read-only zero. An I/O base register resets with bit 0 set. The ROM register at 0x30 also has bit 0 writable.
- R10: `remap_pulse` is high for exactly the cycle after a write's clock edge when that write changed any byte in 0x10-0x27, or changed bit 0 or bit 1 of offset 0x04. Otherwise it stays low.
- R11: `cfg_rvalid` is high for exactly the cycle after a read strobe edge, with `cfg_rdata` holding the result.
- R12: Under reset every byte takes its reset value and `cfg_rvalid` and `remap_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Access strobe, one cycle per access |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 24 | Bus, function index, byte offset |
| cfg_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| cfg_wdata | input | 32 | Write data, byte 0 at the start offset |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| remap_pulse | output | 1 | Base window or decode enable changed |

## Verification
The assertions assume that `cfg_valid` is a single-cycle strobe, and that the address, size and data are stable and known on every strobe edge. They also assume that the size parameters obey the elaboration checks, so that no mask ever reaches a base register's type bits. The bench drives each access for one cycle on the falling edge, always follows it with an idle or known access, and never leaves the strobe at an unknown value after reset. Base sizes are chosen so that every mask byte class occurs: fully writable, partly writable and absent.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

   localparam int unsigned CFG_BYTES = 256;
   localparam int unsigned LANES     = 4;

   typedef logic [7:0]      byte_t;
   typedef logic [6:0][4:0] bar_log2_t;   // index 6 = expansion ROM
   typedef logic [5:0]      bar_io_t;

   localparam byte_t OFF_CMD      = 8'h04;
   localparam byte_t OFF_CACHELN  = 8'h0C;
   localparam byte_t OFF_BAR_LO   = 8'h10;
   localparam byte_t OFF_BAR_HI   = 8'h27;
   localparam byte_t OFF_ROM      = 8'h30;
   localparam byte_t OFF_INTLINE  = 8'h3C;
   localparam byte_t OFF_DEVSPEC  = 8'h40;
   localparam byte_t CMD_WR_BITS  = 8'h07;

   function automatic byte_t size_mask_byte(input logic [4:0] log2, input logic [1:0] lane);
      logic [31:0] full;
      logic [31:0] shifted;
      if (log2 == 5'd0) full = 32'd0;
      else              full = ~((32'd1 << log2) - 32'd1);
      shifted = full >> {lane, 3'b000};
      return shifted[7:0];
   endfunction

   function automatic byte_t writable_mask(input byte_t off, input bar_log2_t l2);
      logic [2:0] n;
      byte_t      m;
      byte_t      rel;
      m = 8'h00;
      if (off >= OFF_DEVSPEC) begin
         m = 8'hFF;
      end else if (off >= OFF_BAR_LO && off <= OFF_BAR_HI) begin
         rel = off - OFF_BAR_LO;
         n   = rel[4:2];
         m   = size_mask_byte(l2[n], off[1:0]);
      end else if (off[7:2] == OFF_ROM[7:2]) begin
         m = size_mask_byte(l2[6], off[1:0]);
         if (off[1:0] == 2'd0 && l2[6] != 5'd0) m[0] = 1'b1;
      end else if (off == OFF_CMD) begin
         m = CMD_WR_BITS;
      end else if (off == OFF_CACHELN || off == OFF_INTLINE) begin
         m = 8'hFF;
      end
      return m;
   endfunction

   function automatic byte_t reset_byte(input byte_t off, input logic [15:0] ven,
                                        input logic [15:0] dev, input byte_t rev,
                                        input logic [23:0] cls, input byte_t hdr,
                                        input bar_log2_t l2, input bar_io_t io);
      byte_t b;
      byte_t rel;
      b = 8'h00;
      case (off)
         8'h00: b = ven[7:0];
         8'h01: b = ven[15:8];
         8'h02: b = dev[7:0];
         8'h03: b = dev[15:8];
         8'h08: b = rev;
         8'h09: b = cls[7:0];
         8'h0A: b = cls[15:8];
         8'h0B: b = cls[23:16];
         8'h0E: b = hdr;
         default: begin
            if (off >= OFF_BAR_LO && off <= OFF_BAR_HI && off[1:0] == 2'd0) begin
               rel = off - OFF_BAR_LO;
               if (io[rel[4:2]] && l2[rel[4:2]] != 5'd0) b = 8'h01;
            end
         end
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import cfg_space_pkg::*;
#(
   parameter logic [7:0] BUS_NUM   = 8'h00,
   parameter int unsigned NUM_FUNCS = 2,
   parameter int unsigned FIDX_W    = 1
) (
   input  logic [23:0]       addr,
   input  logic [1:0]        size,
   output logic              hit,
   output logic [FIDX_W-1:0] fidx,
   output byte_t             off,
   output logic [LANES-1:0]  wr_lanes,
   output logic [LANES-1:0]  rd_lanes,
   output logic [31:0]       miss_word
);

   logic [2:0] req_len;
   logic [2:0] rd_len;
   logic [8:0] lane_end [LANES];

   assign off  = addr[7:0];
   assign fidx = addr[8 +: FIDX_W];
   assign hit  = (addr[23:16] == BUS_NUM) && ({1'b0, addr[15:8]} < 9'(NUM_FUNCS));

   always_comb begin
      case (size)
         2'b00:   begin req_len = 3'd1; miss_word = 32'h0000_00FF; end
         2'b01:   begin req_len = 3'd2; miss_word = 32'h0000_FFFF; end
         default: begin req_len = 3'd4; miss_word = 32'hFFFF_FFFF; end
      endcase
      if (req_len == 3'd4 && off <= 8'hFC)      rd_len = 3'd4;
      else if (req_len >= 3'd2 && off <= 8'hFE) rd_len = 3'd2;
      else                                      rd_len = 3'd1;
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_end[i]  = {1'b0, off} + 9'(i);
         assign wr_lanes[i]  = (3'(i) < req_len) && !lane_end[i][8];
         assign rd_lanes[i]  = (3'(i) < rd_len);
      end
   endgenerate

endmodule

// File: rtl/cfg_wmask_lookup.sv
module cfg_wmask_lookup
   import cfg_space_pkg::*;
#(
   parameter bar_log2_t BAR_LOG2 = '0
) (
   input  byte_t off,
   output byte_t mask
);

   assign mask = writable_mask(off, BAR_LOG2);

endmodule

// File: rtl/cfg_func_store.sv
module cfg_func_store
   import cfg_space_pkg::*;
#(
   parameter logic [15:0] VENDOR   = 16'h0000,
   parameter logic [15:0] DEVICE   = 16'h0000,
   parameter byte_t       REVISION = 8'h00,
   parameter logic [23:0] CLASS    = 24'h000000,
   parameter byte_t       HDR_TYPE = 8'h00,
   parameter bar_log2_t   BAR_LOG2 = '0,
   parameter bar_io_t     BAR_IO   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] lane_en,
   input  byte_t            off,
   input  logic [31:0]      wdata,
   input  logic [31:0]      lane_mask,
   output logic [31:0]      rd_bytes,
   output logic             remap_hit
);

   byte_t      mem [CFG_BYTES];
   byte_t      old_b [LANES];
   byte_t      new_b [LANES];
   byte_t      diff_b [LANES];
   byte_t      idx_b [LANES];
   logic [8:0] sum_b [LANES];

   always_comb begin
      remap_hit = 1'b0;
      rd_bytes  = 32'd0;
      for (int i = 0; i < LANES; i++) begin
         sum_b[i]  = {1'b0, off} + 9'(i);
         idx_b[i]  = sum_b[i][7:0];
         old_b[i]  = mem[idx_b[i]];
         new_b[i]  = (old_b[i] & ~lane_mask[8*i +: 8]) | (wdata[8*i +: 8] & lane_mask[8*i +: 8]);
         diff_b[i] = new_b[i] ^ old_b[i];
         if (!sum_b[i][8]) rd_bytes[8*i +: 8] = old_b[i];
         if (wr_en && lane_en[i]) begin
            if (idx_b[i] >= OFF_BAR_LO && idx_b[i] <= OFF_BAR_HI && diff_b[i] != 8'd0)
               remap_hit = 1'b1;
            if (idx_b[i] == OFF_CMD && diff_b[i][1:0] != 2'b00)
               remap_hit = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < CFG_BYTES; j++)
            mem[j] <= reset_byte(byte_t'(j), VENDOR, DEVICE, REVISION, CLASS, HDR_TYPE,
                                 BAR_LOG2, BAR_IO);
      end else if (wr_en) begin
         for (int i = 0; i < LANES; i++)
            if (lane_en[i]) mem[idx_b[i]] <= new_b[i];
      end
   end

   // R7: identity bytes never move after reset
   assert_id_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable({mem[3], mem[2], mem[1], mem[0], mem[8], mem[14]}));

   // R8: only the three enable bits of the command word can be set
   assert_cmd_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem[4][7:3] == 5'd0) && (mem[5] == 8'd0));

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
   import cfg_space_pkg::*;
#(
   parameter logic [7:0]  BUS_NUM   = 8'h00,
   parameter int unsigned NUM_FUNCS = 2,
   parameter logic [15:0] VENDOR    = 16'hC0DE,
   parameter logic [15:0] DEVICE    = 16'h5A17,
   parameter byte_t       REVISION  = 8'h03,
   parameter logic [23:0] CLASS     = 24'h020000,
   parameter byte_t       HDR_TYPE  = 8'h00,
   parameter bar_log2_t   BAR_LOG2  = {5'd16, 5'd0, 5'd0, 5'd0, 5'd0, 5'd8, 5'd12},
   parameter bar_io_t     BAR_IO    = 6'b000010
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_valid,
   input  logic        cfg_write,
   input  logic [23:0] cfg_addr,
   input  logic [1:0]  cfg_size,
   input  logic [31:0] cfg_wdata,
   output logic        cfg_rvalid,
   output logic [31:0] cfg_rdata,
   output logic        remap_pulse
);

   localparam int unsigned FIDX_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

   initial begin
      assert (NUM_FUNCS >= 1 && NUM_FUNCS <= 256)
         else $error("NUM_FUNCS must lie in 1..256");
      for (int n = 0; n < 6; n++) begin
         if (BAR_IO[n])
            assert (BAR_LOG2[n] == 5'd0 || BAR_LOG2[n] >= 5'd2)
               else $error("I/O base size exponent must be 0 or at least 2");
         else
            assert (BAR_LOG2[n] == 5'd0 || BAR_LOG2[n] >= 5'd4)
               else $error("memory base size exponent must be 0 or at least 4");
      end
   end

   logic              dec_hit;
   logic [FIDX_W-1:0] dec_fidx;
   byte_t             dec_off;
   logic [LANES-1:0]  wr_lanes;
   logic [LANES-1:0]  rd_lanes;
   logic [31:0]       miss_word;
   logic [31:0]       lane_mask;
   logic [31:0]       rd_bus [NUM_FUNCS];
   logic [NUM_FUNCS-1:0] remap_vec;
   logic [31:0]       rd_sel;
   logic [31:0]       rd_keep;
   logic              do_write;

   cfg_addr_decode #(
      .BUS_NUM   (BUS_NUM),
      .NUM_FUNCS (NUM_FUNCS),
      .FIDX_W    (FIDX_W)
   ) u_decode (
      .addr      (cfg_addr),
      .size      (cfg_size),
      .hit       (dec_hit),
      .fidx      (dec_fidx),
      .off       (dec_off),
      .wr_lanes  (wr_lanes),
      .rd_lanes  (rd_lanes),
      .miss_word (miss_word)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_mask
         cfg_wmask_lookup #(.BAR_LOG2(BAR_LOG2)) u_mask (
            .off  (dec_off + byte_t'(i)),
            .mask (lane_mask[8*i +: 8])
         );
         assign rd_keep[8*i +: 8] = {8{rd_lanes[i]}};
      end
   endgenerate

   assign do_write = cfg_valid && cfg_write && dec_hit;

   generate
      for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
         cfg_func_store #(
            .VENDOR   (VENDOR),
            .DEVICE   (DEVICE),
            .REVISION (REVISION),
            .CLASS    (CLASS),
            .HDR_TYPE (HDR_TYPE),
            .BAR_LOG2 (BAR_LOG2),
            .BAR_IO   (BAR_IO)
         ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (do_write && (dec_fidx == FIDX_W'(f))),
            .lane_en   (wr_lanes),
            .off       (dec_off),
            .wdata     (cfg_wdata),
            .lane_mask (lane_mask),
            .rd_bytes  (rd_bus[f]),
            .remap_hit (remap_vec[f])
         );
      end
   endgenerate

   assign rd_sel = rd_bus[dec_fidx] & rd_keep;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rvalid  <= 1'b0;
         cfg_rdata   <= 32'd0;
         remap_pulse <= 1'b0;
      end else begin
         cfg_rvalid  <= cfg_valid && !cfg_write;
         remap_pulse <= do_write && (|remap_vec);
         if (cfg_valid && !cfg_write)
            cfg_rdata <= dec_hit ? rd_sel : miss_word;
      end
   end

   assert_rvalid_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write) |=> cfg_rvalid);

   assert_rvalid_only_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rvalid |-> $past(cfg_valid && !cfg_write));

   assert_remap_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> $past(cfg_valid && cfg_write && dec_hit));

   assert_absent_byte_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write && !dec_hit && cfg_size == 2'b00) |=> (cfg_rdata == 32'h0000_00FF));

endmodule

// File: tb/cfg_space_regfile_bench.sv
module cfg_space_regfile_bench;

   localparam logic [7:0] BUS = 8'h03;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic        cfg_write = 1'b0;
   logic [23:0] cfg_addr = '0;
   logic [1:0]  cfg_size = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_rvalid;
   logic [31:0] cfg_rdata;
   logic        remap_pulse;

   int n_chk = 0;
   int n_bad = 0;
   logic wr_seen = 1'b0;

   logic [31:0] rd_exp [$];
   string       rd_tag [$];
   logic        rm_exp [$];
   string       rm_tag [$];

   always #2.5 clk = ~clk;

   cfg_space_regfile #(.BUS_NUM(BUS), .NUM_FUNCS(2)) u_cfg_space_regfile (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
      .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
      .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .remap_pulse(remap_pulse)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %08h want %08h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] bus, input logic [7:0] fn, input logic [7:0] off,
                     input logic [1:0] sz, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = {bus, fn, off}; cfg_size = sz;
      rd_exp.push_back(exp); rd_tag.push_back(tag);
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] bus, input logic [7:0] fn, input logic [7:0] off,
                     input logic [1:0] sz, input logic [31:0] d, input logic remap,
                     input string tag);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = {bus, fn, off}; cfg_size = sz;
      cfg_wdata = d;
      rm_exp.push_back(remap); rm_tag.push_back(tag);
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
   endtask

   always @(posedge clk) wr_seen <= rst_n && cfg_valid && cfg_write;

   // monitor: compares results as they appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (cfg_rvalid) begin
            if (rd_exp.size() == 0) check(1'b0, "R11 unexpected rvalid", 32'd1, 32'd0);
            else begin
               automatic logic [31:0] e = rd_exp.pop_front();
               automatic string t = rd_tag.pop_front();
               check(cfg_rdata === e, t, cfg_rdata, e);
            end
         end
         if (wr_seen) begin
            automatic logic e = rm_exp.pop_front();
            automatic string t = rm_tag.pop_front();
            check(remap_pulse === e, t, {31'd0, remap_pulse}, {31'd0, e});
         end else if (remap_pulse) begin
            check(1'b0, "R10 pulse without write", 32'd1, 32'd0);
         end
      end
   end

   initial begin
      #(5.0 * 50000);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(cfg_rvalid === 1'b0 && remap_pulse === 1'b0, "R12 outputs in reset",
            {30'd0, cfg_rvalid, remap_pulse}, 32'd0);
      rst_n = 1'b1;
      // R12 / R7 reset identity
      rd(BUS, 8'h00, 8'h00, 2'b10, 32'h5A17C0DE, "R7 R12 id word");
      rd(BUS, 8'h00, 8'h08, 2'b11, 32'h02000003, "R7 rev/class");
      rd(BUS, 8'h00, 8'h14, 2'b10, 32'h00000001, "R9 io reset bit");
      wr(BUS, 8'h00, 8'h00, 2'b10, 32'hFFFFFFFF, 1'b0, "R7 id write no remap");
      rd(BUS, 8'h00, 8'h00, 2'b10, 32'h5A17C0DE, "R7 id unchanged");
      // R8 command register
      wr(BUS, 8'h00, 8'h04, 2'b01, 32'h0000FFFF, 1'b1, "R10 cmd enables set");
      rd(BUS, 8'h00, 8'h04, 2'b10, 32'h00000007, "R8 cmd mask");
      wr(BUS, 8'h00, 8'h04, 2'b00, 32'h00000007, 1'b0, "R10 cmd no change");
      wr(BUS, 8'h00, 8'h04, 2'b00, 32'h00000004, 1'b1, "R10 cmd enables cleared");
      wr(BUS, 8'h00, 8'h04, 2'b00, 32'h00000000, 1'b0, "R10 master bit only");
      rd(BUS, 8'h00, 8'h04, 2'b01, 32'h00000000, "R8 cmd cleared");
      // R9 base registers
      wr(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFFFFFF, 1'b1, "R10 bar0 write");
      rd(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFFF000, "R9 bar0 mask");
      wr(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFFFFFF, 1'b0, "R10 bar0 same value");
      wr(BUS, 8'h00, 8'h14, 2'b10, 32'hFFFFFFFF, 1'b1, "R10 bar1 write");
      rd(BUS, 8'h00, 8'h14, 2'b10, 32'hFFFFFF01, "R9 io bar mask");
      wr(BUS, 8'h00, 8'h18, 2'b10, 32'hFFFFFFFF, 1'b0, "R9 absent bar no remap");
      rd(BUS, 8'h00, 8'h18, 2'b10, 32'h00000000, "R9 absent bar");
      wr(BUS, 8'h00, 8'h30, 2'b10, 32'hFFFFFFFF, 1'b0, "R10 rom outside window");
      rd(BUS, 8'h00, 8'h30, 2'b10, 32'hFFFF0001, "R9 rom mask");
      wr(BUS, 8'h00, 8'h11, 2'b00, 32'h00000011, 1'b1, "R6 partial byte merge");
      rd(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFF1000, "R6 merged bar0");
      // R8 header bytes
      wr(BUS, 8'h00, 8'h0C, 2'b10, 32'hAABBCCDD, 1'b0, "R8 cacheline write");
      rd(BUS, 8'h00, 8'h0C, 2'b10, 32'h000000DD, "R8 cacheline only");
      wr(BUS, 8'h00, 8'h3C, 2'b01, 32'h00001234, 1'b0, "R8 intline write");
      rd(BUS, 8'h00, 8'h3C, 2'b01, 32'h00000034, "R8 intline only");
      // R3 / R4 / R5 device-specific area
      wr(BUS, 8'h00, 8'hFC, 2'b10, 32'h11223344, 1'b0, "R3 top word write");
      rd(BUS, 8'h00, 8'hFC, 2'b10, 32'h11223344, "R3 top word");
      wr(BUS, 8'h00, 8'hFE, 2'b10, 32'hA1B2C3D4, 1'b0, "R5 truncated write");
      rd(BUS, 8'h00, 8'hFE, 2'b10, 32'h0000C3D4, "R4 R5 word at FE");
      rd(BUS, 8'h00, 8'hFD, 2'b10, 32'h0000D433, "R4 word at FD");
      rd(BUS, 8'h00, 8'hFF, 2'b10, 32'h000000C3, "R4 word at FF");
      rd(BUS, 8'h00, 8'hFF, 2'b01, 32'h000000C3, "R4 half at FF");
      wr(BUS, 8'h00, 8'h40, 2'b00, 32'hFFFFFF5A, 1'b0, "R3 byte write");
      wr(BUS, 8'h00, 8'h41, 2'b01, 32'h7777BEEF, 1'b0, "R3 half write");
      rd(BUS, 8'h00, 8'h40, 2'b10, 32'h00BEEF5A, "R3 little-endian");
      rd(BUS, 8'h00, 8'h41, 2'b00, 32'h000000EF, "R3 byte read");
      // R1 function isolation
      rd(BUS, 8'h01, 8'h40, 2'b10, 32'h00000000, "R1 func1 separate");
      rd(BUS, 8'h01, 8'h00, 2'b10, 32'h5A17C0DE, "R1 func1 id");
      wr(BUS, 8'h01, 8'h10, 2'b10, 32'h12345678, 1'b1, "R1 func1 bar write");
      rd(BUS, 8'h01, 8'h10, 2'b10, 32'h12345000, "R1 func1 bar");
      rd(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFF1000, "R1 func0 bar kept");
      // R2 absent targets
      rd(BUS, 8'h02, 8'h00, 2'b00, 32'h000000FF, "R2 absent byte");
      rd(BUS, 8'h02, 8'h00, 2'b01, 32'h0000FFFF, "R2 absent half");
      rd(BUS, 8'h02, 8'h00, 2'b10, 32'hFFFFFFFF, "R2 absent word");
      rd(8'h01, 8'h00, 8'h00, 2'b11, 32'hFFFFFFFF, "R2 other bus");
      wr(8'h01, 8'h00, 8'h10, 2'b10, 32'h00000000, 1'b0, "R2 other bus write");
      wr(8'h01, 8'h00, 8'h40, 2'b00, 32'h00000077, 1'b0, "R2 other bus byte");
      rd(BUS, 8'h00, 8'h40, 2'b00, 32'h0000005A, "R2 write ignored");
      rd(BUS, 8'h00, 8'h10, 2'b10, 32'hFFFF1000, "R2 bar ignored");
      repeat (4) @(negedge clk);
      check(rd_exp.size() == 0 && rm_exp.size() == 0, "R11 all results seen",
            32'(rd_exp.size() + rm_exp.size()), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule